// File: doc/BRIEF.md
# Byte-Wide GPIO Port with Atomic Set/Clear/Toggle Aliases

This block controls one 8-bit general-purpose I/O port on a simple byte-wide memory-mapped register bus. It keeps a direction vector, which becomes the per-pin output enable, and an output vector, which drives the pins. A third register samples the pins through a two-flop synchronizer. A fourth register holds event flags that an external sense unit raises.

The direction and output vectors each have three extra alias addresses. Writing a mask to an alias sets, clears or toggles only the masked bits in one bus cycle, so software never needs a read-modify-write sequence. The sequence cannot be interrupted part-way through. Reading an alias returns the plain register value.

An optional four-register low-address window gives a second, short path to the core registers. It maps direction, output, input and flags, and it does not reach the aliases.

Top module: `gpio_port_atomic`

## Requirements
- R1: After reset, the direction, output and flag registers are all zero, so every pin is an input and `pin_o` is 0.
- R2: A write to port offset 0x0 loads the direction register. `pin_oe_o` follows it with bit n at 1 meaning pin n is an output.
- R3: A write to offset 0x1 ORs the written mask into the direction register. Bits written as 0 keep their value.
- R4: A write to offset 0x2 clears each direction bit whose written bit is 1.
- R5: A write to offset 0x3 XORs the written mask into the direction register.
- R6: The output register at offset 0x4 drives `pin_o`. Its aliases at 0x5, 0x6 and 0x7 apply OR, AND-NOT and XOR in the same way.
- R7: A read of any set, clear or toggle alias returns the current value of its base register.
- R8: A read of offset 0x8 returns `pin_i` as sampled two clock edges earlier.
- R9: A write to offset 0x8 has no effect: `pin_o` and `pin_oe_o` are unchanged.
- R10: Flags at offset 0xC are set by `flag_set_i` and cleared by writing 1. A flag that is raised and cleared in the same cycle ends set.
- R11: The port block is 0x20 bytes at `PORT_BASE`. Unused offsets inside it, and addresses outside both the block and the window, read as 0 and ignore writes.
- R12: When enabled, the window at `VWIN_BASE` has four registers: offset 0 is direction, 1 is output, 2 is input and 3 is flags. A write to offset 1 loads the output register rather than ORing into it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_addr_i | input | AW | Bus byte address |
| bus_wr_i | input | 1 | Write strobe for the current cycle |
| bus_wdata_i | input | PW | Write data |
| bus_rdata_o | output | PW | Read data for `bus_addr_i` (combinational) |
| pin_i | input | PW | Pin levels from the pads |
| pin_o | output | PW | Output levels to the pads |
| pin_oe_o | output | PW | Per-pin output enable |
| flag_set_i | input | PW | Event strobes that raise flag bits |

## Verification
The hardest cases to reach are a flag that is raised and cleared in the same cycle, and the synchronizer latency. For the first, the stimulus drives a write-one-to-clear and a `flag_set_i` pulse on the same bit in the same cycle. For the second, the input register is read one cycle and then two cycles after a pin change, so that both the old and the new value are seen. Each alias is checked against a value built up from a known history of earlier writes. The window's output register is written with a value that would give a different result if the write had acted as a set alias.

// File: rtl/gpio_atomic_pkg.sv
package gpio_atomic_pkg;
  localparam int OFS_W   = 5;
  localparam int WIN_W   = 2;
  localparam logic [OFS_W-1:0] OFS_IN  = 5'h08;
  localparam logic [OFS_W-1:0] OFS_FLG = 5'h0C;

  typedef enum logic [2:0] {SEL_NONE, SEL_DIR, SEL_OUT, SEL_IN, SEL_FLG} sel_e;
  typedef enum logic [1:0] {OP_LOAD, OP_SET, OP_CLR, OP_TGL} op_e;

  typedef struct packed {
    sel_e sel;
    op_e  op;
  } acc_t;
endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_atomic_pkg::*;
#(
  parameter int          AW        = 12,
  parameter logic [AW-1:0] PORT_BASE = 12'h620,
  parameter logic [AW-1:0] VWIN_BASE = 12'h014,
  parameter bit          VWIN_EN   = 1'b1
) (
  input  logic [AW-1:0] addr_i,
  output acc_t          acc_o
);
  logic port_hit;
  logic win_hit;
  logic [OFS_W-1:0] ofs;

  assign port_hit = addr_i[AW-1:OFS_W] == PORT_BASE[AW-1:OFS_W];
  assign ofs      = addr_i[OFS_W-1:0];

  generate
    if (VWIN_EN) begin : g_win
      assign win_hit = addr_i[AW-1:WIN_W] == VWIN_BASE[AW-1:WIN_W];
    end else begin : g_nowin
      assign win_hit = 1'b0;
    end
  endgenerate

  always_comb begin
    acc_o.sel = SEL_NONE;
    acc_o.op  = OP_LOAD;
    if (port_hit) begin
      // Offsets 0..7: bit 2 picks the register, bits 1:0 the alias kind
      if (ofs[OFS_W-1:3] == '0) begin
        acc_o.sel = ofs[2] ? SEL_OUT : SEL_DIR;
        acc_o.op  = op_e'(ofs[1:0]);
      end else if (ofs == OFS_IN) begin
        acc_o.sel = SEL_IN;
      end else if (ofs == OFS_FLG) begin
        acc_o.sel = SEL_FLG;
      end
    end else if (win_hit) begin
      unique case (addr_i[WIN_W-1:0])
        2'd0:    acc_o.sel = SEL_DIR;
        2'd1:    acc_o.sel = SEL_OUT;
        2'd2:    acc_o.sel = SEL_IN;
        default: acc_o.sel = SEL_FLG;
      endcase
    end
  end
endmodule

// File: rtl/gpio_alias_reg.sv
module gpio_alias_reg
  import gpio_atomic_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  op_e          op_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] nxt;

  always_comb begin
    unique case (op_i)
      OP_SET:  nxt = q_o | wdata_i;
      OP_CLR:  nxt = q_o & ~wdata_i;
      OP_TGL:  nxt = q_o ^ wdata_i;
      default: nxt = wdata_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= nxt;
  end

  // Also covers the output register's set alias (R6)
  assert_alias_or_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && op_i == OP_SET) |=> q_o == ($past(q_o) | $past(wdata_i)));

  assert_alias_andnot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && op_i == OP_CLR) |=> q_o == ($past(q_o) & ~$past(wdata_i)));

  assert_alias_xor_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && op_i == OP_TGL) |=> q_o == ($past(q_o) ^ $past(wdata_i)));

  assert_hold_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(q_o));
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      q_o  <= '0;
    end else begin
      s1_q <= d_i;
      q_o  <= s1_q;
    end
  end

  // Count the edges since reset so that the check below looks no further back
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            age_q <= '0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  assert_two_stage_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd2) |-> q_o == $past(d_i, 2));
endmodule

// File: rtl/gpio_port_atomic.sv
module gpio_port_atomic
  import gpio_atomic_pkg::*;
#(
  parameter int            AW        = 12,
  parameter int            PW        = 8,
  parameter logic [AW-1:0] PORT_BASE = 12'h620,
  parameter logic [AW-1:0] VWIN_BASE = 12'h014,
  parameter bit            VWIN_EN   = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] bus_addr_i,
  input  logic          bus_wr_i,
  input  logic [PW-1:0] bus_wdata_i,
  output logic [PW-1:0] bus_rdata_o,
  input  logic [PW-1:0] pin_i,
  output logic [PW-1:0] pin_o,
  output logic [PW-1:0] pin_oe_o,
  input  logic [PW-1:0] flag_set_i
);
  acc_t          acc;
  logic [PW-1:0] dir_q, out_q, in_q, flg_q;
  logic          dir_we, out_we, flg_we;

  gpio_addr_dec #(
    .AW(AW), .PORT_BASE(PORT_BASE), .VWIN_BASE(VWIN_BASE), .VWIN_EN(VWIN_EN)
  ) u_dec (
    .addr_i(bus_addr_i),
    .acc_o (acc)
  );

  assign dir_we = bus_wr_i && acc.sel == SEL_DIR;
  assign out_we = bus_wr_i && acc.sel == SEL_OUT;
  assign flg_we = bus_wr_i && acc.sel == SEL_FLG;

  gpio_alias_reg #(.W(PW)) u_dir (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(dir_we), .op_i(acc.op),
    .wdata_i(bus_wdata_i), .q_o(dir_q)
  );

  gpio_alias_reg #(.W(PW)) u_out (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(out_we), .op_i(acc.op),
    .wdata_i(bus_wdata_i), .q_o(out_q)
  );

  gpio_sync #(.W(PW)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pin_i), .q_o(in_q)
  );

  // A new event beats a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flg_q <= '0;
    else         flg_q <= (flg_q & ~(flg_we ? bus_wdata_i : '0)) | flag_set_i;
  end

  always_comb begin
    unique case (acc.sel)
      SEL_DIR: bus_rdata_o = dir_q;
      SEL_OUT: bus_rdata_o = out_q;
      SEL_IN:  bus_rdata_o = in_q;
      SEL_FLG: bus_rdata_o = flg_q;
      default: bus_rdata_o = '0;
    endcase
  end

  assign pin_o    = out_q;
  assign pin_oe_o = dir_q;

  assert_in_write_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && acc.sel == SEL_IN) |=> ($stable(pin_o) && $stable(pin_oe_o)));

  assert_flag_set_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|flag_set_i) |=> ((flg_q & $past(flag_set_i)) == $past(flag_set_i)));

  assert_unmapped_reads_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc.sel == SEL_NONE) |-> bus_rdata_o == '0);
endmodule

// File: tb/gpio_port_atomic_tb_top.sv
module gpio_port_atomic_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] bus_addr_i = '0;
  logic        bus_wr_i = 1'b0;
  logic [7:0]  bus_wdata_i = '0;
  logic [7:0]  bus_rdata_o;
  logic [7:0]  pin_i = '0;
  logic [7:0]  pin_o;
  logic [7:0]  pin_oe_o;
  logic [7:0]  flag_set_i = '0;

  always #10 clk_i = ~clk_i;

  gpio_port_atomic dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .bus_addr_i(bus_addr_i), .bus_wr_i(bus_wr_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .pin_i(pin_i),
    .pin_o(pin_o), .pin_oe_o(pin_oe_o), .flag_set_i(flag_set_i)
  );

  typedef struct {
    int       kind;  // 0 read data, 1 pin_o, 2 pin_oe_o
    logic [7:0] exp;
    string    tag;
  } item_t;

  item_t queue_q[$];
  event  sample_ev;
  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;

  task automatic push(input int kind, input logic [7:0] exp, input string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    queue_q.push_back(it);
    -> sample_ev;
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d, input logic [7:0] fs);
    @(negedge clk_i);
    bus_addr_i = a; bus_wdata_i = d; bus_wr_i = 1'b1; flag_set_i = fs;
  endtask

  task automatic idle(input logic [7:0] fs);
    @(negedge clk_i);
    bus_wr_i = 1'b0; flag_set_i = fs;
  endtask

  task automatic rd(input logic [11:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk_i);
    bus_wr_i = 1'b0; flag_set_i = '0; bus_addr_i = a;
    push(0, exp, tag);
  endtask

  task automatic look(input int kind, input logic [7:0] exp, input string tag);
    @(negedge clk_i);
    bus_wr_i = 1'b0; flag_set_i = '0;
    push(kind, exp, tag);
  endtask

  task automatic set_pins(input logic [7:0] v);
    @(negedge clk_i);
    bus_wr_i = 1'b0; flag_set_i = '0; pin_i = v;
  endtask

  // Monitor: compares the oldest expected item shortly after the driver's negedge
  initial begin
    forever begin
      @(sample_ev);
      #2;
      begin
        item_t it;
        logic [7:0] act;
        it = queue_q.pop_front();
        act = (it.kind == 0) ? bus_rdata_o : (it.kind == 1) ? pin_o : pin_oe_o;
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s actual %02h expected %02h", it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1
    rd(12'h620, 8'h00, "R1 dir reset");
    rd(12'h624, 8'h00, "R1 out reset");
    look(2, 8'h00, "R1 oe reset");
    look(1, 8'h00, "R1 pin_o reset");
    rd(12'h62C, 8'h00, "R1 flags reset");
    // R2
    wr(12'h620, 8'hA5, 8'h00);
    look(2, 8'hA5, "R2 oe after dir load");
    rd(12'h620, 8'hA5, "R2 dir readback");
    // R3, R4, R5 with R7 alias readback
    wr(12'h621, 8'h0F, 8'h00);
    rd(12'h621, 8'hAF, "R3 dir set / R7 alias read");
    wr(12'h622, 8'h81, 8'h00);
    rd(12'h622, 8'h2E, "R4 dir clear / R7 alias read");
    look(2, 8'h2E, "R4 oe after clear");
    wr(12'h623, 8'hFF, 8'h00);
    rd(12'h623, 8'hD1, "R5 dir toggle / R7 alias read");
    // R6
    wr(12'h624, 8'h3C, 8'h00);
    look(1, 8'h3C, "R6 out load");
    wr(12'h625, 8'h41, 8'h00);
    look(1, 8'h7D, "R6 out set");
    wr(12'h626, 8'h0C, 8'h00);
    look(1, 8'h71, "R6 out clear");
    wr(12'h627, 8'h18, 8'h00);
    look(1, 8'h69, "R6 out toggle");
    rd(12'h627, 8'h69, "R7 out toggle alias read");
    rd(12'h625, 8'h69, "R7 out set alias read");
    // R9
    wr(12'h628, 8'hFF, 8'h00);
    look(1, 8'h69, "R9 pin_o after input write");
    look(2, 8'hD1, "R9 oe after input write");
    // R8: one edge after the change the old value, two edges the new
    set_pins(8'h5A);
    rd(12'h628, 8'h00, "R8 input one edge");
    rd(12'h628, 8'h5A, "R8 input two edges");
    rd(12'h016, 8'h5A, "R12 window input");
    // R10
    idle(8'h33);
    rd(12'h62C, 8'h33, "R10 flags raised");
    wr(12'h62C, 8'h11, 8'h00);
    rd(12'h62C, 8'h22, "R10 w1c");
    wr(12'h62C, 8'h22, 8'h02);
    rd(12'h62C, 8'h02, "R10 set wins same cycle");
    wr(12'h017, 8'h02, 8'h00);
    rd(12'h62C, 8'h00, "R12 window flags clear");
    // R11
    wr(12'h640, 8'hFF, 8'h00);
    rd(12'h620, 8'hD1, "R11 dir unchanged by outside write");
    rd(12'h624, 8'h69, "R11 out unchanged by outside write");
    rd(12'h640, 8'h00, "R11 outside reads zero");
    rd(12'h629, 8'h00, "R11 unused offset reads zero");
    wr(12'h62A, 8'hFF, 8'h00);
    look(1, 8'h69, "R11 unused offset write ignored");
    // R12
    wr(12'h014, 8'h0F, 8'h00);
    rd(12'h620, 8'h0F, "R12 window dir write");
    rd(12'h014, 8'h0F, "R12 window dir read");
    wr(12'h015, 8'hF0, 8'h00);
    look(1, 8'hF0, "R12 window out is load, not set");
    rd(12'h015, 8'hF0, "R12 window out read");
    idle(8'h00);
    idle(8'h00);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule